// File: doc/BRIEF.md
# Edge-Latched Static RAM Core

This block is a clocked model of a small static memory of 1024 words by 4 bits. Two active-low strobes control it, a chip enable and a write enable, and both are sampled by a fast system clock. A memory cycle starts when the chip enable is seen going from high to low. At that moment the word address is captured into an internal register. Until the enable goes high again, the cycle serves one read or one write at that captured address, and the address pins are ignored.

The model splits the shared data pin into three signals: a write-data input, a read-data output and an output-drive flag. This gives the three-state behaviour of a common data bus without real tri-state drivers. The output is driven only while the enable is low and the write strobe is high. Read data appears a fixed number of clocks after the cycle starts; that number is a parameter. A write is stored when the period in which both strobes are low comes to an end. The write strobe may also stay low across several enable cycles, which gives a run of writes.

Top module: `edge_latched_sram`

## Requirements
- R1: Every one of the 1024 4-bit words keeps the value last written to it, and a read cycle at that address returns this value.
- R2: The address is captured from the value on `addr` at the first clock edge that samples `ce_n` low after a clock edge that sampled it high. Changes on `addr` after that edge have no effect until the next such falling edge.
- R3: The storage is 64 rows of 64 bits. The row is `addr[9:4]` and the column within each group is `addr[3:0]`. Data bit b is held in column b*16+`addr[3:0]`. The addresses 0, 15, 16, 1008 and 1023 do not alias.
- R4: After each clock edge, `q_oe` is 1 exactly when that edge sampled `ce_n`=0 and `we_n`=1. It is 0 whenever the edge sampled `ce_n`=1.
- R5: A clock edge that samples `we_n`=0 leaves `q_oe` at 0, so that write data can be placed on the bus.
- R6: `q_out` is 0 whenever `q_oe` is 0. It is also 0 until READ_LAT clocks have passed since the edge that detected the enable falling.
- R7: A write period is a run of edges that sample both `ce_n`=0 and `we_n`=0. It ends at the first edge where either strobe is sampled high, whichever rises first. The word then stores the `d_in` sampled at the last edge of the period, and the write completes one clock after the end of the period.
- R8: If `we_n` stays low across several enable cycles, each enable cycle writes its own captured address.
- R9: Synchronous reset returns the block to idle: `q_oe`=0, `q_out`=0, and the address register cleared. The stored words are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip enable; its falling edge starts a cycle |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 10 | Word address, captured when a cycle starts |
| d_in | input | 4 | Write data from the shared bus |
| q_out | output | 4 | Read data; 0 when not driven or not yet valid |
| q_oe | output | 1 | High when the block drives the shared bus |

## Verification
Each input goes through one register before it reaches any logic. So `q_oe` reflects the strobes sampled at the previous clock edge. Read data follows READ_LAT edges after the edge that sampled the enable low. A stored word becomes readable one edge after the write period ends. The bench holds a behavioural model that takes the same samples of the ports at every rising edge and applies these delays to them. It compares `q_oe` and `q_out` with the model at every falling edge, where the registered outputs are settled, and skips data checks only for words that have never been written.

// File: rtl/esram_pkg.sv
package esram_pkg;

    // Control strobes as captured by the input register stage.
    typedef struct packed {
        logic ce_n;
        logic we_n;
    } ctl_t;

    // What the current enable cycle is doing.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // enable high, bus released
        PH_WAIT  = 2'd1,   // reading, data not yet valid
        PH_READ  = 2'd2,   // reading, data valid
        PH_WRITE = 2'd3    // write strobe low, bus released
    } phase_e;

    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1};

    // Enable falling: previous sample high, current sample low.
    function automatic logic enable_fell(input logic prev_ce_n, input ctl_t cur);
        return prev_ce_n & ~cur.ce_n;
    endfunction

    // Both strobes low: a write period is in progress.
    function automatic logic write_window(input ctl_t cur);
        return ~cur.ce_n & ~cur.we_n;
    endfunction

endpackage

// File: rtl/esram_ctrl.sv
module esram_ctrl
    import esram_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 4,
    parameter int READ_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d_in,
    output logic [ADDR_W-1:0] cell_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              q_oe,
    output logic              rd_ready
);

    localparam int CNT_W = $clog2(READ_LAT + 1);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(READ_LAT);

    ctl_t              cur_q;
    logic              ce_prev_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [ADDR_W-1:0] lat_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_act_q;
    logic [DATA_W-1:0] wdata_q;

    logic   fall;
    logic   wr_now;
    phase_e phase;

    assign fall   = enable_fell(ce_prev_q, cur_q);
    assign wr_now = write_window(cur_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= CTL_IDLE;
            ce_prev_q <= 1'b1;
            addr_q    <= '0;
            din_q     <= '0;
            lat_q     <= '0;
            cnt_q     <= '0;
            wr_act_q  <= 1'b0;
            wdata_q   <= '0;
        end else begin
            cur_q     <= '{ce_n: ce_n, we_n: we_n};
            ce_prev_q <= cur_q.ce_n;
            addr_q    <= addr;
            din_q     <= d_in;
            if (fall)
                lat_q <= addr_q;
            if (cur_q.ce_n)
                cnt_q <= '0;
            else if (cnt_q != LAT_C)
                cnt_q <= cnt_q + 1'b1;
            wr_act_q <= wr_now;
            if (wr_now)
                wdata_q <= din_q;
        end
    end

    always_comb begin
        if (cur_q.ce_n)
            phase = PH_IDLE;
        else if (!cur_q.we_n)
            phase = PH_WRITE;
        else if (cnt_q == LAT_C)
            phase = PH_READ;
        else
            phase = PH_WAIT;
    end

    assign q_oe      = (phase == PH_WAIT) || (phase == PH_READ);
    assign rd_ready  = (phase == PH_READ);
    assign wr_en     = wr_act_q & ~wr_now;
    assign wr_data   = wdata_q;
    assign cell_addr = lat_q;

    // R2: the captured address moves only after a detected enable fall
    p_hold_addr_r2: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(lat_q));

    // R4: an enable sampled high releases the bus on the next cycle
    p_oe_off_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        $past(ce_n) |-> !q_oe);

    // R5: a low write strobe sampled at the port keeps the bus released
    p_write_hides_bus_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!we_n) |-> !q_oe);

    // R7: a store only follows strobes that were both low at the ports
    p_commit_after_window_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(!ce_n && !we_n, 2));

endmodule

// File: rtl/esram_array.sv
module esram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4,
    parameter int ROW_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int COL_W = ADDR_W - ROW_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int GROUP = 1 << COL_W;

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    assign row = cell_addr[ADDR_W-1:COL_W];
    assign col = cell_addr[COL_W-1:0];

    // One column group per data bit; together they form one row of the matrix.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic [GROUP-1:0] bank [ROWS];

        always_ff @(posedge clk) begin
            if (wr_en)
                bank[row][col] <= wr_data[b];
        end

        assign rd_data[b] = bank[row][col];
    end

endmodule

// File: rtl/edge_latched_sram.sv
module edge_latched_sram
    import esram_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 4,
    parameter int ROW_W    = 6,
    parameter int READ_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q_out,
    output logic              q_oe
);

    logic [ADDR_W-1:0] cell_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              rd_ready;

    esram_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .READ_LAT(READ_LAT)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .d_in     (d_in),
        .cell_addr(cell_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .q_oe     (q_oe),
        .rd_ready (rd_ready)
    );

    esram_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .ROW_W (ROW_W)
    ) array_i (
        .clk      (clk),
        .wr_en    (wr_en),
        .cell_addr(cell_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    assign q_out = rd_ready ? rd_data : '0;

    // R6: no data leaves the block while the bus is released
    p_quiet_when_released_r6: assert property (@(posedge clk) disable iff (rst)
        !q_oe |-> (q_out == '0));

endmodule

// File: tb/edge_latched_sram_tb_top.sv
module edge_latched_sram_tb_top;

    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       ce_n;
    logic       we_n;
    logic [9:0] addr;
    logic [3:0] d_in;
    logic [3:0] q_out;
    logic       q_oe;

    always #5 clk = ~clk;

    edge_latched_sram #(.READ_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .d_in(d_in), .q_out(q_out), .q_oe(q_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit chk_en = 0;
    bit done = 0;

    // Behavioural reference model, updated from port samples at each rising edge.
    int mem_m [1024];
    bit ce_prev = 1;
    bit per_prev = 0;
    bit pend = 0;
    int pend_a, pend_d;
    int d_last = 0;
    int lat = 0;
    int since = 0;
    bit exp_oe = 0;
    int exp_q = 0;
    bit exp_known = 1;

    initial foreach (mem_m[i]) mem_m[i] = -1;

    always @(posedge clk) begin
        if (rst) begin
            ce_prev = 1; per_prev = 0; pend = 0; since = 0; lat = 0;
            exp_oe = 0; exp_q = 0; exp_known = 1;
        end else begin
            bit per;
            if (pend) begin
                mem_m[pend_a] = pend_d;
                pend = 0;
            end
            per = !ce_n && !we_n;
            if (per_prev && !per) begin
                pend = 1; pend_a = lat; pend_d = d_last;
            end
            if (per) d_last = int'(d_in);
            if (ce_prev && !ce_n) begin
                lat = int'(addr); since = 0;
            end else if (!ce_n && since < LAT) begin
                since++;
            end
            exp_oe = !ce_n && we_n;
            if (exp_oe && since >= LAT) begin
                exp_known = (mem_m[lat] >= 0);
                exp_q = exp_known ? mem_m[lat] : 0;
            end else begin
                exp_known = 1; exp_q = 0;
            end
            ce_prev = ce_n;
            per_prev = per;
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0d expected %0d", req, $time, got, exp);
        end
    endtask

    // Every cycle: bus drive (R4, R5) and data (R1, R6) against the model.
    always @(negedge clk) begin
        if (chk_en) begin
            check(q_oe === exp_oe, we_n ? "R4 q_oe" : "R5 q_oe", int'(q_oe), int'(exp_oe));
            if (exp_known)
                check(q_out === 4'(exp_q), (since < LAT || !exp_oe) ? "R6 q_out" : "R1 q_out",
                      int'(q_out), exp_q);
        end
    end

    task automatic idle(input int n);
        ce_n = 1; we_n = 1;
        repeat (n) @(negedge clk);
    endtask

    // Write, enable falls first; write strobe rises first and takes the data (R7).
    task automatic wr_e_first(input int a, input int d);
        ce_n = 0; we_n = 1; addr = 10'(a);
        @(negedge clk);
        addr = 10'(a ^ 10'h155);           // R2: must be ignored
        we_n = 0; d_in = 4'(d);
        repeat (2) @(negedge clk);
        we_n = 1; d_in = 4'(~d);           // data after the period is not stored
        repeat (LAT + 1) @(negedge clk);
        idle(1);
    endtask

    // Write, strobe low first; enable rises first and takes the data (R7).
    task automatic wr_w_first(input int a, input int d);
        we_n = 0; d_in = 4'(d ^ 5);
        @(negedge clk);
        ce_n = 0; addr = 10'(a);
        @(negedge clk);
        addr = 10'(~a); d_in = 4'(d);
        repeat (2) @(negedge clk);
        ce_n = 1; d_in = 4'(~d);
        @(negedge clk);
        idle(1);
    endtask

    // Read with the address bus and data bus moving after capture (R2, R6).
    task automatic rd(input int a);
        ce_n = 0; we_n = 1; addr = 10'(a);
        @(negedge clk);
        addr = 10'(a + 1); d_in = 4'(a * 3);
        repeat (LAT + 2) @(negedge clk);
        idle(1);
    endtask

    initial begin
        rst = 1; ce_n = 1; we_n = 1; addr = '0; d_in = '0;
        repeat (3) @(negedge clk);
        // R9: idle state after reset
        check(q_oe === 1'b0, "R9 reset q_oe", int'(q_oe), 0);
        check(q_out === 4'd0, "R9 reset q_out", int'(q_out), 0);
        chk_en = 1;
        rst = 0;
        idle(2);

        wr_e_first(37, 4'hA);   // R7 write strobe rises first
        rd(37);                 // R1, R2, R6
        wr_w_first(512, 4'h5);  // R7 enable rises first
        rd(512);

        // R8: write strobe held low over several enable cycles
        we_n = 0;
        for (int i = 0; i < 6; i++) begin
            int a;
            case (i)
                0: a = 0; 1: a = 15; 2: a = 16;
                3: a = 1008; 4: a = 1023; default: a = 63;
            endcase
            ce_n = 0; addr = 10'(a); d_in = 4'(i + 3);
            @(negedge clk);
            addr = 10'(a ^ 1);
            @(negedge clk);
            ce_n = 1;
            @(negedge clk);
        end
        idle(2);
        // R3: boundary addresses each hold their own word
        rd(0); rd(15); rd(16); rd(1008); rd(1023); rd(63);

        // R4/R5: write strobe pulse inside a read cycle, then reading again
        ce_n = 0; we_n = 1; addr = 10'd37;
        repeat (LAT + 1) @(negedge clk);
        we_n = 0; d_in = 4'h3;
        @(negedge clk);
        we_n = 1;
        repeat (LAT + 2) @(negedge clk);
        idle(1);
        rd(37);

        // R9: reset leaves the stored words alone
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        idle(1);
        rd(512); rd(1023);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule